// File: doc/BRIEF.md
# Byte Transmit Queue with Multi-Width Enqueue and Drain Interrupt

This block sits between a processor's register bus and a serial transmitter. Software puts one, two or four bytes into a 16-byte queue with a single bus write. The number of bytes depends on which of three data addresses it writes. A transmitter then pulls the bytes out one at a time through a valid/ready byte port. Because a multi-byte write lands in the queue in one clock cycle, the transmitter never sees only part of a write, even while it is draining at the same time.

Software can read the current occupancy at any time. It is told that a burst has finished by an interrupt. That interrupt is raised only when the queue goes from holding exactly one byte to holding none. It is not raised while the queue simply stays empty. The interrupt is kept in a sticky pending bit, which software clears by writing 1 to it. A write that would not fit is dropped as a whole and recorded in a sticky overflow bit.

Top module: `txq_top`

## Requirements
- R1: After reset the queue is empty: depth reads 0, `tx_valid` is 0 and `irq` is 0. The occupancy never exceeds 16.
- R2: A write to offset 0x00 enqueues `bus_wdata[7:0]`. A write to offset 0x04 enqueues `bus_wdata[15:0]` as 2 bytes. A write to offset 0x08 enqueues all of `bus_wdata` as 4 bytes. All bytes of one write enter the queue on the same clock edge.
- R3: The bytes of a write are queued least-significant byte first, after all bytes already queued.
- R4: A read of offset 0x0C returns the occupancy in bits [4:0] and zero above. The value changes on the clock edge that applies a push or pop.
- R5: `tx_valid` is 1 exactly when the queue is not empty, and `tx_data` is then the oldest byte. A byte is removed on each edge where `tx_valid` and `tx_ready` are both 1.
- R6: The pending bit, and `irq` with it, becomes 1 on the edge where occupancy goes from exactly 1 to 0.
- R7: Pending is set on no other edge. It is not set while the queue stays empty, and not set when a pop at occupancy 1 coincides with an accepted write.
- R8: A write whose byte count, added to the occupancy before that edge's pop, exceeds 16 is discarded entirely. It also sets the sticky overflow bit.
- R9: Offset 0x10 reads the pending bit in bit 0 and the overflow bit in bit 1. Writing 1 to either bit clears it. A new set event on the same edge wins over the clear.
- R10: Writes to 0x0C or to unmapped offsets change nothing. Reads of the data offsets and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_valid | output | 1 | Queue holds a byte for the transmitter |
| tx_data | output | 8 | Oldest queued byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| irq | output | 1 | Drain interrupt (pending bit) |

## Verification
A behavioural queue model is stepped alongside the design. Directed phases come first. A single byte drained with the transmitter always ready tells the 1-to-0 edge apart from a level empty flag. Filling the queue with four-byte words while the transmitter stalls, then adding one more byte, separates an accepted write from a rejected one at the 16-byte limit. A byte write landing on the same edge as the pop of the last byte shows that the edge check looks at the next occupancy and not only the current one. A long random phase follows. It mixes all offsets, clears and stalls, so that push/pop overlap and clear/set collisions occur at every occupancy.

// File: rtl/txq_pkg.sv
// Package: register offsets and fixed widths shared by the transmit queue.
// Assumes a byte-addressed bus with 5 offset bits.
package txq_pkg;
    localparam logic [4:0] OFS_TX1   = 5'h00;
    localparam logic [4:0] OFS_TX2   = 5'h04;
    localparam logic [4:0] OFS_TX4   = 5'h08;
    localparam logic [4:0] OFS_DEPTH = 5'h0C;
    localparam logic [4:0] OFS_STAT  = 5'h10;
    localparam int         LANES     = 4;      // bytes in one bus word
endpackage

// File: rtl/txq_regif.sv
// Register decode: turns a bus write into a push request of 1, 2 or 4 bytes.
// Accepts it only if it fits, and produces the status clears and read data.
// Assumes the occupancy input is the registered count before this edge's pop.
module txq_regif #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic          bus_wr,
    input  logic [4:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [CW-1:0] occ,
    input  logic          pend,
    input  logic          ovf,
    output logic [2:0]    req_len,
    output logic          push,
    output logic          ovf_evt,
    output logic          clr_pend,
    output logic          clr_ovf
);
    import txq_pkg::*;

    logic [CW:0] sum;

    // Byte count requested by this write (0 if no data write).
    always_comb begin
        req_len = 3'd0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_TX1: req_len = 3'd1;
                OFS_TX2: req_len = 3'd2;
                OFS_TX4: req_len = 3'd4;
                default: req_len = 3'd0;
            endcase
        end
    end

    // Capacity check: whole write accepted or whole write rejected.
    always_comb begin
        sum     = {1'b0, occ} + (CW+1)'(req_len);
        push    = (req_len != 3'd0) && (sum <= (CW+1)'(DEPTH));
        ovf_evt = (req_len != 3'd0) && !push;
    end

    // Write-one-to-clear strobes for the status register.
    always_comb begin
        clr_pend = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[0];
        clr_ovf  = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[1];
    end

    // Read mux: depth and status readable, everything else reads zero.
    always_comb begin
        case (bus_addr)
            OFS_DEPTH: bus_rdata = 32'(occ);
            OFS_STAT:  bus_rdata = {30'd0, ovf, pend};
            default:   bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/txq_store.sv
// Circular byte store: writes up to four bytes at the tail in one edge and
// pops one byte from the head. Assumes DEPTH is a power of two and that the
// caller never pushes more than fits.
module txq_store #(
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [2:0]    push_len,
    input  logic [31:0]   push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] occ_next
);
    import txq_pkg::*;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    // Next occupancy after this edge's push and pop.
    always_comb begin
        occ_next = occ + (push ? CW'(push_len) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            occ <= occ_next;
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
            if (push) wr_ptr <= wr_ptr + PW'(push_len);
        end
    end

    // Byte lanes, least significant first, written together on one edge.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (push && (3'(k) < push_len))
                mem[wr_ptr + PW'(k)] <= push_data[8*k +: 8];
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/txq_irq.sv
// Sticky status bits: drain pending (set on the 1-to-0 occupancy edge) and
// overflow. Each is cleared by a write-one strobe; a set on the same edge wins.
module txq_irq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] occ_next,
    input  logic          ovf_evt,
    input  logic          clr_pend,
    input  logic          clr_ovf,
    output logic          pend,
    output logic          ovf
);
    logic drain_edge;

    // Edge detect: exactly one byte now, none after this edge.
    assign drain_edge = (occ == CW'(1)) && (occ_next == CW'(0));

    // Pending and overflow flags with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (drain_edge)    pend <= 1'b1;
            else if (clr_pend) pend <= 1'b0;
            if (ovf_evt)       ovf  <= 1'b1;
            else if (clr_ovf)  ovf  <= 1'b0;
        end
    end
endmodule

// File: rtl/txq_top.sv
// Transmit queue top: register interface, byte store and drain interrupt.
// Assumes a single-cycle register bus and a transmitter with valid/ready.
module txq_top #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ;
    logic [CW-1:0] occ_next;
    logic [2:0]    req_len;
    logic          push, pop, ovf_evt, clr_pend, clr_ovf, pend, ovf;

    assign tx_valid = (occ != CW'(0));
    assign pop      = tx_valid && tx_ready;
    assign irq      = pend;

    txq_regif #(.DEPTH(DEPTH), .CW(CW)) u_regif (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .occ(occ), .pend(pend), .ovf(ovf),
        .req_len(req_len), .push(push), .ovf_evt(ovf_evt),
        .clr_pend(clr_pend), .clr_ovf(clr_ovf)
    );

    txq_store #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_len(req_len),
        .push_data(bus_wdata), .pop(pop), .head(tx_data),
        .occ(occ), .occ_next(occ_next)
    );

    txq_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst_n(rst_n), .occ(occ), .occ_next(occ_next),
        .ovf_evt(ovf_evt), .clr_pend(clr_pend), .clr_ovf(clr_ovf),
        .pend(pend), .ovf(ovf)
    );
endmodule

// File: rtl/txq_checker.sv
// Checker: temporal properties of occupancy, overflow and the drain flag.
module txq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] occ,
    input logic          pop,
    input logic          push,
    input logic [2:0]    req_len,
    input logic          pend,
    input logic          ovf
);
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    a_r2_occ_track: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> int'(occ) == int'($past(occ)) + int'($past(req_len)) - ($past(pop) ? 1 : 0));

    a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_len != 3'd0 && !push) |=> ovf);

    a_r8_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_len != 3'd0 && !push) |=> int'(occ) == int'($past(occ)) - ($past(pop) ? 1 : 0));

    a_r6_drain_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(1) && pop && !push) |=> pend);

    a_r7_only_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> (!pend || $past(occ == CW'(1) && pop && !push)));
endmodule

bind txq_top txq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .occ(occ), .pop(pop), .push(push),
    .req_len(req_len), .pend(pend), .ovf(ovf)
);

// File: tb/txq_top_test.sv
// Bench: behavioural queue model stepped each clock and compared with the ports.
module txq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    byte unsigned q[$];
    bit   m_pend = 1'b0;
    bit   m_ovf = 1'b0;

    txq_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Port checks against the model state (called away from the edge).
    task automatic check_outputs(input bit rose);
        check("R5", "tx_valid", tx_valid, q.size() != 0);
        if (q.size() != 0) check("R3", "tx_data", tx_data, q[0]);
        check(rose ? "R6" : "R7", "irq", irq, m_pend);
    endtask

    // Read-data check for the offset currently driven.
    task automatic check_read();
        case (bus_addr)
            5'h0C:   check("R4", "depth read", bus_rdata, q.size());
            5'h10:   check("R9", "status read", bus_rdata, {m_ovf, m_pend});
            default: check("R10", "data/unmapped read", bus_rdata, 0);
        endcase
    endtask

    // One clock: drive at negedge, step model at posedge, check at next negedge.
    task automatic cyc(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit rdy);
        int n;
        bit pop, ok, edge_evt, was_pend;
        bus_wr = wr; bus_addr = a; bus_wdata = d; tx_ready = rdy;
        #1;
        check_read();
        @(posedge clk);
        n = 0;
        if (wr) n = (a == 5'h00) ? 1 : (a == 5'h04) ? 2 : (a == 5'h08) ? 4 : 0;
        pop = (q.size() != 0) && rdy;
        ok = (n != 0) && (q.size() + n <= DEPTH);
        edge_evt = (q.size() == 1) && pop && !ok;
        if (pop) void'(q.pop_front());
        if (ok) for (int k = 0; k < n; k++) q.push_back(d[8*k +: 8]);
        was_pend = m_pend;
        if (edge_evt) m_pend = 1'b1;
        else if (wr && a == 5'h10 && d[0]) m_pend = 1'b0;
        if (n != 0 && !ok) m_ovf = 1'b1;
        else if (wr && a == 5'h10 && d[1]) m_ovf = 1'b0;
        @(negedge clk);
        check_outputs(m_pend && !was_pend);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "tx_valid after reset", tx_valid, 0);
        check("R1", "irq after reset", irq, 0);
        bus_addr = 5'h0C; #1;
        check("R1", "depth after reset", bus_rdata, 0);
        @(negedge clk);
        // R7: idle empty queue raises nothing
        repeat (4) cyc(0, 5'h0C, 0, 1);
        // R2/R6: single byte drained with ready high
        cyc(1, 5'h00, 32'h0000_00A5, 1);
        cyc(0, 5'h0C, 0, 1);
        cyc(0, 5'h10, 0, 0);
        check("R6", "irq after 1-to-0 drain", irq, 1);
        cyc(1, 5'h10, 32'h1, 0);
        // R2/R3/R8: fill with words while stalled, then overflow
        cyc(1, 5'h08, 32'h4433_2211, 0);
        cyc(1, 5'h04, 32'hBEEF_6655, 0);
        cyc(1, 5'h08, 32'hAA99_8877, 0);
        cyc(1, 5'h08, 32'hEEDD_CCBB, 0);
        cyc(1, 5'h04, 32'h0000_1100, 0);
        cyc(0, 5'h0C, 0, 0);
        check("R8", "depth at full", bus_rdata, 16);
        cyc(1, 5'h00, 32'h0000_0077, 0);
        cyc(0, 5'h10, 0, 0);
        check("R8", "overflow bit", bus_rdata[1], 1);
        // R10: writes to depth and unmapped offsets ignored
        cyc(1, 5'h0C, 32'hFFFF_FFFF, 0);
        cyc(1, 5'h14, 32'hFFFF_FFFF, 0);
        cyc(0, 5'h0C, 0, 0);
        // R9: clear overflow, drain to one byte
        cyc(1, 5'h10, 32'h2, 1);
        while (q.size() > 1) cyc(0, 5'h0C, 0, 1);
        // R7: enqueue coincides with pop of the last byte
        cyc(1, 5'h00, 32'h0000_005A, 1);
        check("R7", "no irq on overlapped push/pop", irq, 0);
        cyc(0, 5'h0C, 0, 1);
        check("R6", "irq after last drain", irq, 1);
        // R9: clear colliding with a new edge
        cyc(1, 5'h10, 32'h1, 0);
        cyc(1, 5'h00, 32'h0000_0001, 0);
        cyc(1, 5'h10, 32'h1, 1);
        check("R9", "set wins over clear", irq, 1);
        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic [4:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2: a = 5'h00;
                3, 4:    a = 5'h04;
                5, 6:    a = 5'h08;
                7:       a = 5'h0C;
                8:       a = 5'h10;
                default: a = 5'h14;
            endcase
            cyc($urandom_range(0, 2) != 0, a, $urandom, $urandom_range(0, 3) != 0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule